// File: doc/BRIEF.md
# PCIe Gen3 Transmit Block-to-Lane Gearbox

This block sits in the transmit path of a Gen3 lane. It turns a stream of 130-bit blocks into a steady stream of 32-bit words for the serializer. Each block is a 2-bit sync header followed by 128 payload bits. The source delivers a block over four accepted input cycles, called beats. The first beat carries the header together with 32 payload bits, 34 bits in all. Each of the other three beats carries 32 payload bits.

Every accepted beat produces one full 32-bit output word. The block does this by keeping the bits left over from earlier beats in a residue register, together with a count of how many bits are held there. Each block leaves 2 more bits in the residue than the one before it. After 16 blocks the residue holds exactly one whole word. The source must then leave one cycle empty, the gap slot. In that cycle the block sends out the stored word and starts again with an empty residue.

If the source drops its valid strobe outside the gap slot, the block raises an error flag. It does the same if the source sends a beat during the gap slot, or if the block-start strobe does not match the beat position. The flag lets a neighbouring controller see that alignment has been lost. In a dropped-valid or start-mismatch cycle the alignment state is not changed.

Top module: `gen3_tx_gearbox`

## Requirements
- R1: A synchronous active-high reset clears the output word to zero, clears the error flag, empties the residue and sets the beat and block counters to zero, so the first block after reset starts with no bits held.
- R2: Bits are sent in transmit order, and output bit i is the i-th bit of that order. A block's transmit order is sync header bit 0, then sync header bit 1, then bits 0 to 31 of the start beat's data, then bits 0 to 31 of each following beat, in the order the beats arrive.
- R3: Each accepted beat produces exactly one output word. The word holds the next 32 bits of the transmit stream and is visible on the output one clock after the edge that accepts the beat.
- R4: A start beat adds 34 bits to the stream and every other beat adds 32. A block that begins with 2k bits already held, for k from 0 to 15, ends with 2k+2 bits held.
- R5: After 16 complete blocks, that is 64 accepted beats, the next cycle is the gap slot. In the gap slot the output word is the 32 bits that remain in the residue. After the gap the residue is empty and the 16-block pattern starts again from zero.
- R6: If in_valid is low outside the gap slot, align_err is high one clock later. In that case the output word repeats its previous value and the residue, offset and counters stay unchanged.
- R7: A beat with in_valid high is rejected in the same way as R6 in two cases: in_start is high on a beat that is not the first of its block, or in_start is low on the first beat of a block.
- R8: If in_valid is high in the gap slot, align_err is high one clock later and the input is ignored. The stored word is still sent out and the pattern restarts.
- R9: align_err is a one-cycle indication. It is low one clock after any cycle that accepts a beat, and after a gap slot with in_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The beat on in_data (and in_hdr) is offered |
| in_start | input | 1 | The offered beat is the first of a block |
| in_hdr | input | 2 | Sync header, used on the start beat only |
| in_data | input | 32 | Payload bits of the beat |
| out_data | output | 32 | Lane word, bit 0 first in transmit order |
| align_err | output | 1 | Input timing violation in the previous cycle |

## Verification
The output word and the error flag both come from registers in the datapath and the sequencer. Each result is therefore due exactly one rising edge after the cycle that causes it. The bench changes the inputs on the falling edge and checks the outputs on the next falling edge, so there is exactly one register stage between a stimulus and its check. The expected words come from a bit queue in the bench. The queue is filled from the offered beats in transmit order and emptied 32 bits per accepted beat or gap slot, while rejected beats leave it untouched.

// File: rtl/gen3_gb_pkg.sv
package gen3_gb_pkg;

   // What the datapath does in one cycle
   typedef enum logic [1:0] {
      GB_HOLD  = 2'd0,   // keep all state, repeat the output word
      GB_TAKE  = 2'd1,   // merge the offered beat into the stream
      GB_DRAIN = 2'd2    // send the full residue word, restart offset
   } gb_act_e;

endpackage

// File: rtl/gen3_gb_seq.sv
module gen3_gb_seq
   import gen3_gb_pkg::*;
#(
   parameter int LANE_W = 32,
   parameter int HDR_W  = 2,
   parameter int BEATS  = 4,
   localparam int NBLK   = LANE_W / HDR_W,
   localparam int BLK_W  = $clog2(NBLK + 1),
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_start,
   output gb_act_e          act,
   output logic             first_beat,
   output logic             gap_slot,
   output logic             viol,
   output logic [BLK_W-1:0] blk_cnt
);

   logic [BEAT_W-1:0] beat_q;
   logic [BLK_W-1:0]  blk_q;

   // The gap slot decision comes before any check on the input.
   always_comb begin
      gap_slot   = (blk_q == BLK_W'(NBLK));
      first_beat = (beat_q == '0);
      act        = GB_HOLD;
      viol       = 1'b0;
      if (gap_slot) begin
         act  = GB_DRAIN;
         viol = in_valid;
      end else if (!in_valid) begin
         viol = 1'b1;
      end else if (in_start != first_beat) begin
         viol = 1'b1;
      end else begin
         act = GB_TAKE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_q <= '0;
         blk_q  <= '0;
      end else begin
         unique case (act)
            GB_TAKE: begin
               if (beat_q == BEAT_W'(BEATS - 1)) begin
                  beat_q <= '0;
                  blk_q  <= blk_q + 1'b1;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            GB_DRAIN: begin
               beat_q <= '0;
               blk_q  <= '0;
            end
            default: ;
         endcase
      end
   end

   assign blk_cnt = blk_q;

   // R5
   blk_bound_chk: assert property (@(posedge clk) disable iff (rst)
      blk_q <= BLK_W'(NBLK));

   // R5
   gap_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      gap_slot |-> (beat_q == '0));

endmodule

// File: rtl/gen3_gb_merge.sv
module gen3_gb_merge #(
   parameter int LANE_W    = 32,
   parameter int HDR_W     = 2,
   parameter bit LOG_SHIFT = 1'b1,
   localparam int CNT_W = $clog2(LANE_W + 1),
   localparam int SUM_W = 2 * LANE_W
)(
   input  logic [LANE_W-1:0] res,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              first,
   input  logic [HDR_W-1:0]  hdr,
   input  logic [LANE_W-1:0] data,
   output logic [LANE_W-1:0] word,
   output logic [LANE_W-1:0] res_nxt,
   output logic [CNT_W-1:0]  cnt_nxt
);

   logic [SUM_W-1:0] ins;
   logic [SUM_W-1:0] shifted;
   logic [SUM_W-1:0] merged;

   // New bits in transmit order: the header sits below the data on a start beat
   assign ins = first ? SUM_W'({data, hdr}) : SUM_W'(data);

   generate
      if (LOG_SHIFT) begin : g_log
         logic [SUM_W-1:0] stg [0:CNT_W];
         assign stg[0] = ins;
         for (genvar s = 0; s < CNT_W; s++) begin : g_stage
            assign stg[s+1] = cnt[s] ? (stg[s] << (1 << s)) : stg[s];
         end
         assign shifted = stg[CNT_W];
      end else begin : g_flat
         assign shifted = ins << cnt;
      end
   endgenerate

   assign merged  = SUM_W'(res) | shifted;
   assign word    = merged[LANE_W-1:0];
   assign res_nxt = merged[SUM_W-1:LANE_W];
   assign cnt_nxt = first ? (cnt + CNT_W'(HDR_W)) : cnt;

endmodule

// File: rtl/gen3_gb_datapath.sv
module gen3_gb_datapath
   import gen3_gb_pkg::*;
#(
   parameter int LANE_W    = 32,
   parameter int HDR_W     = 2,
   parameter bit LOG_SHIFT = 1'b1,
   localparam int CNT_W = $clog2(LANE_W + 1)
)(
   input  logic              clk,
   input  logic              rst,
   input  gb_act_e           act,
   input  logic              first_beat,
   input  logic [HDR_W-1:0]  in_hdr,
   input  logic [LANE_W-1:0] in_data,
   output logic [LANE_W-1:0] out_data,
   output logic [CNT_W-1:0]  res_cnt
);

   logic [LANE_W-1:0] res_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LANE_W-1:0] out_q;
   logic [LANE_W-1:0] word;
   logic [LANE_W-1:0] res_nxt;
   logic [CNT_W-1:0]  cnt_nxt;

   gen3_gb_merge #(
      .LANE_W    (LANE_W),
      .HDR_W     (HDR_W),
      .LOG_SHIFT (LOG_SHIFT)
   ) u_merge (
      .res     (res_q),
      .cnt     (cnt_q),
      .first   (first_beat),
      .hdr     (in_hdr),
      .data    (in_data),
      .word    (word),
      .res_nxt (res_nxt),
      .cnt_nxt (cnt_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         cnt_q <= '0;
         out_q <= '0;
      end else begin
         unique case (act)
            GB_TAKE: begin
               out_q <= word;
               res_q <= res_nxt;
               cnt_q <= cnt_nxt;
            end
            GB_DRAIN: begin
               out_q <= res_q;
               res_q <= '0;
               cnt_q <= '0;
            end
            default: ;
         endcase
      end
   end

   assign out_data = out_q;
   assign res_cnt  = cnt_q;

   // R4
   res_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(LANE_W));

   // R5
   drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (act == GB_DRAIN) |=> (cnt_q == '0 && res_q == '0));

endmodule

// File: rtl/gen3_tx_gearbox.sv
module gen3_tx_gearbox
   import gen3_gb_pkg::*;
#(
   parameter int LANE_W    = 32,
   parameter int HDR_W     = 2,
   parameter int BEATS     = 4,
   parameter bit LOG_SHIFT = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_start,
   input  logic [HDR_W-1:0]  in_hdr,
   input  logic [LANE_W-1:0] in_data,
   output logic [LANE_W-1:0] out_data,
   output logic              align_err
);

   localparam int NBLK  = LANE_W / HDR_W;
   localparam int BLK_W = $clog2(NBLK + 1);
   localparam int CNT_W = $clog2(LANE_W + 1);

   generate
      if (HDR_W < 1 || HDR_W >= LANE_W) begin : g_bad_hdr
         $error("gen3_tx_gearbox: HDR_W must lie between 1 and LANE_W-1");
      end
      if (LANE_W % HDR_W != 0) begin : g_bad_ratio
         $error("gen3_tx_gearbox: LANE_W must be a multiple of HDR_W");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("gen3_tx_gearbox: BEATS must be at least 2");
      end
   endgenerate

   gb_act_e          act;
   logic             first_beat;
   logic             gap_slot;
   logic             viol;
   logic [BLK_W-1:0] blk_cnt;
   logic [CNT_W-1:0] res_cnt;
   logic             err_q;

   gen3_gb_seq #(
      .LANE_W (LANE_W),
      .HDR_W  (HDR_W),
      .BEATS  (BEATS)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_start   (in_start),
      .act        (act),
      .first_beat (first_beat),
      .gap_slot   (gap_slot),
      .viol       (viol),
      .blk_cnt    (blk_cnt)
   );

   gen3_gb_datapath #(
      .LANE_W    (LANE_W),
      .HDR_W     (HDR_W),
      .LOG_SHIFT (LOG_SHIFT)
   ) u_dp (
      .clk        (clk),
      .rst        (rst),
      .act        (act),
      .first_beat (first_beat),
      .in_hdr     (in_hdr),
      .in_data    (in_data),
      .out_data   (out_data),
      .res_cnt    (res_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= viol;
   end

   assign align_err = err_q;

   // R1
   rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_data == '0 && !align_err));

   // R4
   offset_step_chk: assert property (@(posedge clk) disable iff (rst)
      (first_beat && !gap_slot) |-> (int'(res_cnt) == HDR_W * int'(blk_cnt)));

   // R5
   gap_full_chk: assert property (@(posedge clk) disable iff (rst)
      gap_slot |-> (res_cnt == CNT_W'(LANE_W)));

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !gap_slot) |=> (align_err && $stable(out_data)));

   // R8
   gap_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (gap_slot && in_valid) |=> align_err);

   // R9
   err_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (act == GB_TAKE) |=> !align_err);

endmodule

// File: tb/gen3_tx_gearbox_tb.sv
`timescale 1ns/1ps
module gen3_tx_gearbox_tb;

   localparam int M_TAKE  = 0;
   localparam int M_HOLD  = 1;
   localparam int M_DRAIN = 2;
   localparam int NTAB    = 6;

   // Blocks laid out in transmit order: bit 0 is sent first
   localparam logic [129:0] BLK_TAB [0:NTAB-1] = '{
      {128'h0, 2'b01},
      {{4{32'hFFFF_FFFF}}, 2'b10},
      {{4{32'hAAAA_5555}}, 2'b01},
      {32'h8000_0001, 32'h0000_0000, 32'hFFFF_0000, 32'h0000_FFFF, 2'b10},
      {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hCAFE_F00D, 2'b01},
      {32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 2'b11}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_start = 1'b0;
   logic [1:0]  in_hdr = '0;
   logic [31:0] in_data = '0;
   logic [31:0] out_data;
   logic        align_err;

   int          checks = 0;
   int          errors = 0;
   bit          q[$];
   logic [31:0] last_out = '0;

   always #10 clk = ~clk;

   gen3_tx_gearbox u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_start  (in_start),
      .in_hdr    (in_hdr),
      .in_data   (in_data),
      .out_data  (out_data),
      .align_err (align_err)
   );

   task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act_v, exp_v);
      end
   endtask

   function automatic logic [31:0] pop_word();
      logic [31:0] w;
      for (int i = 0; i < 32; i++) w[i] = (q.size() > 0) ? q.pop_front() : 1'b0;
      return w;
   endfunction

   function automatic logic [129:0] mk_blk(int n);
      logic [129:0] b;
      b[1:0] = n[0] ? 2'b10 : 2'b01;
      for (int k = 0; k < 4; k++)
         b[2+32*k +: 32] = (32'(n) * 32'h0100_0193) ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A0F_C3E1;
      return b;
   endfunction

   // Drive one cycle (called just after a falling edge) and check its result
   task automatic step(logic v, logic s, logic [1:0] h, logic [31:0] d,
                       int mode, logic exp_err, string req);
      logic [31:0] exp_w;
      in_valid = v; in_start = s; in_hdr = h; in_data = d;
      if (mode == M_TAKE) begin
         if (s) begin
            q.push_back(h[0]);
            q.push_back(h[1]);
         end
         for (int i = 0; i < 32; i++) q.push_back(d[i]);
         exp_w = pop_word();
      end else if (mode == M_DRAIN) begin
         exp_w = pop_word();
      end else begin
         exp_w = last_out;
      end
      @(negedge clk);
      chk(req, out_data, exp_w);
      chk({req, " err"}, {31'b0, align_err}, {31'b0, exp_err});
      last_out = exp_w;
   endtask

   task automatic send_block(logic [129:0] b, string req);
      step(1'b1, 1'b1, b[1:0], b[33:2], M_TAKE, 1'b0, req);
      for (int k = 1; k < 4; k++)
         step(1'b1, 1'b0, 2'b00, b[2+32*k +: 32], M_TAKE, 1'b0, req);
   endtask

   initial begin
      #4_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", out_data, 32'h0);
      chk("R1 err", {31'b0, align_err}, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 idle", {31'b0, align_err}, 32'h1);  // valid low outside gap (R6)
      last_out = out_data;

      // Round A: table patterns then generated blocks (R2, R3, R4)
      for (int i = 0; i < 16; i++)
         send_block((i < NTAB) ? BLK_TAB[i] : mk_blk(i), (i < 2) ? "R2" : ((i < 8) ? "R3" : "R4"));
      // R5: gap slot drains the surplus word
      step(1'b0, 1'b0, 2'b00, 32'h0, M_DRAIN, 1'b0, "R5");
      chk("R5 empty", 32'(q.size()), 32'h0);

      // Round B: rejections in the middle of the pattern
      begin
         logic [129:0] b;
         b = mk_blk(100);
         step(1'b1, 1'b1, b[1:0], b[33:2], M_TAKE, 1'b0, "R5 restart");
         step(1'b0, 1'b0, 2'b00, 32'hFFFF_FFFF, M_HOLD, 1'b1, "R6");
         step(1'b1, 1'b0, 2'b00, b[65:34], M_TAKE, 1'b0, "R9");
         step(1'b1, 1'b1, 2'b11, 32'h1357_9BDF, M_HOLD, 1'b1, "R7 late start");
         step(1'b1, 1'b0, 2'b00, b[97:66], M_TAKE, 1'b0, "R9 resume");
         step(1'b1, 1'b0, 2'b00, b[129:98], M_TAKE, 1'b0, "R6 state held");
         b = mk_blk(101);
         step(1'b1, 1'b0, 2'b10, 32'h2468_ACE0, M_HOLD, 1'b1, "R7 missing start");
         send_block(b, "R7 recovered");
      end
      for (int i = 2; i < 16; i++) send_block(mk_blk(200 + i), "R4");
      // R8: valid high in the gap slot is ignored
      step(1'b1, 1'b1, 2'b01, 32'hFACE_B00C, M_DRAIN, 1'b1, "R8");
      chk("R8 empty", 32'(q.size()), 32'h0);
      // Pattern restarts from offset zero after the violated gap
      send_block(BLK_TAB[4], "R8 restart");
      send_block(BLK_TAB[5], "R2");
      step(1'b0, 1'b0, 2'b00, 32'h0, M_HOLD, 1'b1, "R6 end");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule